// File: doc/BRIEF.md
# Transfer Length and DMA Completion Controller

This block runs one information-transfer phase between a host memory DMA engine and a target device. A start strobe loads a 16-bit transfer count. A count of zero stands for 65536 bytes. The block then caps that count by the magnitude of a signed residual byte count. The sign of the residual gives the direction: a negative value means data flows toward the device. The capped value becomes the remaining DMA length.

Data is then moved in chunks. Each time the target reports how many bytes it can supply or accept, the block issues one chunk request of the smaller of that amount and the remaining length. It waits for the DMA engine to report that chunk done, then updates the residual, the remaining length and the target's available byte count. The block decides when the transfer counts as complete. Completion can come at once, or it can be deferred until the target supplies data again.

On completion the block sets the interrupt and terminal-count bits of its status register. It writes the bus-service code into the interrupt register and emits a one-cycle completion pulse. Around the block, that pulse clears the sequence, FIFO-flags and count registers and raises the interrupt line. A command-collection mode issues a single chunk toward the device of at most 32 bytes, and that chunk produces no completion.

Top module: `xfer_dma_ctl`

## Requirements
- R1: After reset, req_valid_o and cmpl_o are 0, and status_o, intr_o, resid_o and remain_o are all 0.
- R2: A transfer count of 0 is taken as 65536 bytes, so remain_o can reach 65536 when the residual magnitude is at least that large.
- R3: On start, the granted length is min(count, |residual|). With cmd_mode_i high it is min(count, 32).
- R4: On start, status bit 4 (terminal count) is cleared and remain_o takes the granted length, one cycle after the start strobe.
- R5: A chunk request carries length min(remaining, available). req_dir_o is 1 (toward the device) when the residual is negative. When the chunk is done, the residual goes up by the length if req_dir_o was 1 and down by the length otherwise. The remaining and available lengths both drop by the chunk length.
- R6: If a finished chunk leaves available target bytes unconsumed, completion is signalled in the cycle after chunk done.
- R7: After a chunk that empties the available bytes, completion follows only for a from-device chunk that leaves remaining length 0 and a residual above 0. In every other case no completion is signalled and the block waits.
- R8: Completion sets status bits 7 and 4 (0x90), keeps the other status bits, sets intr_o to 0x10, and pulses cmpl_o high for one cycle.
- R9: A target-done strobe clears the residual, the remaining length and the available count. It sets status_o to 0x93 (phase field bits 2:0 = 3) and intr_o to 0x10, and pulses cmpl_o.
- R10: When target data arrives and the remaining length is nonzero, a chunk is requested. If the remaining length is 0, a transfer size is pending and the residual is at or below 0, the deferred completion is signalled instead. Completion clears the pending transfer size, so it fires only once.
- R11: With no available target bytes, no chunk is requested and all state holds.
- R12: req_valid_o, req_len_o and req_dir_o stay stable until req_ready_i. Only one chunk is outstanding, and each request length is nonzero.
- R13: In command-collection mode, start issues one toward-device request of the granted length. Its chunk-done clears the residual and the remaining length and signals no completion.
- R14: A residual load sets resid_o and writes status_o to phase 0 (negative residual) or phase 1 (otherwise), with bits 7:3 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resid_ld_i | input | 1 | Load residual byte count (idle only) |
| resid_in_i | input | RW | Signed residual value to load |
| start_i | input | 1 | Start-transfer strobe (idle only) |
| cmd_mode_i | input | 1 | Command-collection mode for this start |
| count_i | input | CW | Transfer count register value |
| avail_vld_i | input | 1 | Target reports available bytes |
| avail_len_i | input | CW+1 | Available byte count from the target |
| tgt_done_i | input | 1 | Target reports command finished |
| req_valid_o | output | 1 | Chunk request valid |
| req_ready_i | input | 1 | DMA engine accepts the chunk |
| req_len_o | output | CW+1 | Chunk length in bytes |
| req_dir_o | output | 1 | 1 = toward device, 0 = from device |
| cdone_i | input | 1 | DMA engine finished the chunk |
| resid_o | output | RW | Current signed residual |
| remain_o | output | CW+1 | Remaining DMA length |
| status_o | output | 8 | Status register image |
| intr_o | output | 8 | Interrupt register image |
| cmpl_o | output | 1 | Completion pulse |

## Verification
An error in the remaining or available length shows at once in the next req_len_o. It also shows in remain_o one cycle after the chunk-done strobe. A wrong residual sign flips req_dir_o on the next request, and it moves the completion decision for a read that empties the target's data. A lost or stale pending transfer size shows up only later: the next data-available strobe either misses its deferred completion or produces an extra one. The bench therefore follows every transfer through several data arrivals.

// File: rtl/xfer_pkg.sv
// Shared types and register codes for the transfer controller.
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2
    } xfer_state_t;

    localparam logic [7:0] STAT_IRQ  = 8'h80;
    localparam logic [7:0] STAT_TC   = 8'h10;
    localparam logic [7:0] INTR_SVC  = 8'h10;
    localparam logic [2:0] PH_OUT    = 3'd0;
    localparam logic [2:0] PH_IN     = 3'd1;
    localparam logic [2:0] PH_STATUS = 3'd3;
endpackage

// File: rtl/xfer_grant.sv
// Granted-length calculation.
// Decodes the transfer count (zero means 2**CW) and caps it by the
// residual magnitude, or by CMD_MAX in command-collection mode.
// Assumes the residual never holds the most negative RW-bit value.
module xfer_grant #(
    parameter int CW      = 16,
    parameter int RW      = 24,
    parameter int CMD_MAX = 32
) (
    input  logic [CW-1:0] count_i,
    input  logic          cmd_i,
    input  logic [RW-1:0] resid_i,
    output logic [CW:0]   cnt_o,
    output logic [CW:0]   grant_o
);
    localparam int LW = CW + 1;
    localparam int MW = (RW > LW) ? RW : LW;
    localparam logic [LW-1:0] CMD_LIM = LW'(CMD_MAX);

    logic [RW-1:0] mag;
    logic [MW-1:0] mag_w;
    logic [MW-1:0] cnt_w;

    // decode count, take magnitude, pick the smaller bound
    always_comb begin
        cnt_o = (count_i == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, count_i};
        mag   = resid_i[RW-1] ? ((~resid_i) + RW'(1)) : resid_i;
        mag_w = MW'(mag);
        cnt_w = MW'(cnt_o);
        if (cmd_i) begin
            grant_o = (cnt_o < CMD_LIM) ? cnt_o : CMD_LIM;
        end else begin
            grant_o = (mag_w < cnt_w) ? mag_w[LW-1:0] : cnt_o;
        end
    end
endmodule

// File: rtl/xfer_chunk.sv
// Chunk sizing: the next chunk is the smaller of the remaining DMA length
// and the bytes the target has available. Purely combinational.
module xfer_chunk #(
    parameter int LW = 17
) (
    input  logic [LW-1:0] remain_i,
    input  logic [LW-1:0] avail_i,
    output logic [LW-1:0] len_o
);
    // minimum of the two bounds
    assign len_o = (avail_i < remain_i) ? avail_i : remain_i;
endmodule

// File: rtl/xfer_stat.sv
// Status and interrupt register images.
// Target-done wins over every other update. A residual load rewrites the
// phase. Completion sets the interrupt and terminal-count bits, and a start
// clears terminal count. Assumes load, start and completion never coincide
// with target-done except as the top module sequences them.
module xfer_stat
    import xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_i,
    input  logic       ld_neg_i,
    input  logic       clr_tc_i,
    input  logic       cmpl_i,
    input  logic       tdone_i,
    output logic [7:0] status_o,
    output logic [7:0] intr_o
);
    // register update with target-done priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            intr_o   <= '0;
        end else if (tdone_i) begin
            status_o <= STAT_IRQ | STAT_TC | {5'b0, PH_STATUS};
            intr_o   <= INTR_SVC;
        end else begin
            if (ld_i) begin
                status_o <= {5'b0, ld_neg_i ? PH_OUT : PH_IN};
            end else if (cmpl_i) begin
                status_o <= status_o | STAT_IRQ | STAT_TC;
            end else if (clr_tc_i) begin
                status_o <= status_o & ~STAT_TC;
            end
            if (cmpl_i) begin
                intr_o <= INTR_SVC;
            end
        end
    end

    // R9
    tdone_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdone_i |=> (status_o == 8'h93) && (intr_o == 8'h10));

    // R14
    load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !tdone_i) |=> (status_o[7:3] == 5'd0));
endmodule

// File: rtl/xfer_dma_ctl.sv
// Transfer length and DMA completion controller (top).
// Tracks a signed residual byte count (negative = toward device), the
// remaining DMA length, the target's available bytes and the pending
// transfer size. Issues one chunk request at a time and decides when the
// transfer completes. Assumes residual load, start, data-available and
// target-done arrive only while no chunk is outstanding.
module xfer_dma_ctl
    import xfer_pkg::*;
#(
    parameter int CW      = 16,
    parameter int RW      = 24,
    parameter int CMD_MAX = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          resid_ld_i,
    input  logic [RW-1:0] resid_in_i,
    input  logic          start_i,
    input  logic          cmd_mode_i,
    input  logic [CW-1:0] count_i,
    input  logic          avail_vld_i,
    input  logic [CW:0]   avail_len_i,
    input  logic          tgt_done_i,
    output logic          req_valid_o,
    input  logic          req_ready_i,
    output logic [CW:0]   req_len_o,
    output logic          req_dir_o,
    input  logic          cdone_i,
    output logic [RW-1:0] resid_o,
    output logic [CW:0]   remain_o,
    output logic [7:0]    status_o,
    output logic [7:0]    intr_o,
    output logic          cmpl_o
);
    localparam int LW = CW + 1;

    xfer_state_t   state;
    logic [RW-1:0] resid;
    logic [LW-1:0] remain, avail, xsize, len_q;
    logic          cmd_act, dir_q;

    logic [LW-1:0] cnt_full, grant, ch_rem, ch_av, chunk_len, issue_len;
    logic [LW-1:0] ev_avail, ev_remain;
    logic [RW-1:0] ev_resid;
    logic          in_idle, do_tdone, do_start, do_avail, do_ld, do_cdone;
    logic          resid_pos, ev_pos, issue, issue_dir, cmpl_set;

    xfer_grant #(.CW(CW), .RW(RW), .CMD_MAX(CMD_MAX)) u_grant (
        .count_i (count_i),
        .cmd_i   (cmd_mode_i),
        .resid_i (resid),
        .cnt_o   (cnt_full),
        .grant_o (grant)
    );

    xfer_chunk #(.LW(LW)) u_chunk (
        .remain_i (ch_rem),
        .avail_i  (ch_av),
        .len_o    (chunk_len)
    );

    // event decode, one event accepted per idle cycle
    always_comb begin
        in_idle  = (state == ST_IDLE);
        do_tdone = in_idle && tgt_done_i;
        do_start = in_idle && !tgt_done_i && start_i;
        do_avail = in_idle && !tgt_done_i && !start_i && avail_vld_i;
        do_ld    = in_idle && !tgt_done_i && !start_i && !avail_vld_i && resid_ld_i;
        do_cdone = (state == ST_BUSY) && cdone_i;
    end

    // chunk sizing inputs: a fresh grant on start, fresh data on arrival
    always_comb begin
        ch_rem = do_start ? grant : remain;
        ch_av  = do_avail ? avail_len_i : avail;
    end

    // post-chunk bookkeeping values
    always_comb begin
        ev_avail  = avail - len_q;
        ev_remain = remain - len_q;
        ev_resid  = dir_q ? (resid + RW'(len_q)) : (resid - RW'(len_q));
        resid_pos = !resid[RW-1] && (resid != '0);
        ev_pos    = !ev_resid[RW-1] && (ev_resid != '0);
    end

    // request issue and completion decisions
    always_comb begin
        issue     = 1'b0;
        issue_len = chunk_len;
        issue_dir = resid[RW-1];
        cmpl_set  = 1'b0;
        if (do_tdone) begin
            cmpl_set = 1'b1;
        end else if (do_start) begin
            if (cmd_mode_i) begin
                issue     = 1'b1;
                issue_len = grant;
                issue_dir = 1'b1;
            end else if (avail != '0) begin
                issue    = (chunk_len != '0);
                cmpl_set = (chunk_len == '0);
            end
        end else if (do_avail) begin
            if (remain != '0) begin
                issue = (avail_len_i != '0);
            end else begin
                cmpl_set = (xsize != '0) && !resid_pos;
            end
        end else if (do_cdone && !cmd_act) begin
            cmpl_set = (ev_avail != '0) ||
                       (!dir_q && (ev_remain == '0) && ev_pos);
        end
    end

    // state machine and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            resid   <= '0;
            remain  <= '0;
            avail   <= '0;
            xsize   <= '0;
            len_q   <= '0;
            dir_q   <= 1'b0;
            cmd_act <= 1'b0;
            cmpl_o  <= 1'b0;
        end else begin
            cmpl_o <= cmpl_set;
            unique case (state)
                ST_IDLE: begin
                    if (do_tdone) begin
                        resid  <= '0;
                        remain <= '0;
                        avail  <= '0;
                    end else if (do_start) begin
                        remain  <= grant;
                        xsize   <= cnt_full;
                        cmd_act <= cmd_mode_i;
                    end else if (do_avail) begin
                        avail <= avail_len_i;
                    end else if (do_ld) begin
                        resid <= resid_in_i;
                    end
                    if (issue) begin
                        state <= ST_REQ;
                        len_q <= issue_len;
                        dir_q <= issue_dir;
                    end
                    if (cmpl_set) begin
                        xsize <= '0;
                    end
                end
                ST_REQ: begin
                    if (req_ready_i) begin
                        state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (do_cdone) begin
                        state <= ST_IDLE;
                        if (cmd_act) begin
                            resid   <= '0;
                            remain  <= '0;
                            xsize   <= '0;
                            cmd_act <= 1'b0;
                        end else begin
                            avail  <= ev_avail;
                            remain <= ev_remain;
                            resid  <= ev_resid;
                            if (cmpl_set) begin
                                xsize <= '0;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    xfer_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (do_ld),
        .ld_neg_i (resid_in_i[RW-1]),
        .clr_tc_i (do_start),
        .cmpl_i   (cmpl_set),
        .tdone_i  (do_tdone),
        .status_o (status_o),
        .intr_o   (intr_o)
    );

    assign req_valid_o = (state == ST_REQ);
    assign req_len_o   = len_q;
    assign req_dir_o   = dir_q;
    assign resid_o     = resid;
    assign remain_o    = remain;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_len_o) && $stable(req_dir_o)));

    // R12
    req_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_len_o != '0));

    // R13
    cmd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && cmd_act) |-> (req_len_o <= LW'(CMD_MAX)) && req_dir_o);

    // R5
    req_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !cmd_act) |-> ((req_len_o <= remain) && (req_len_o <= avail)));

    // R8
    cmpl_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_o |-> ((intr_o == 8'h10) && status_o[7] && status_o[4]));

    // R4
    start_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_start && !cmpl_set) |=> !status_o[4]);
endmodule

// File: tb/test_xfer_dma_ctl.sv
module test_xfer_dma_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int RW = 24;
    localparam int LW = CW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          resid_ld_i = 1'b0;
    logic [RW-1:0] resid_in_i = '0;
    logic          start_i = 1'b0;
    logic          cmd_mode_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          avail_vld_i = 1'b0;
    logic [LW-1:0] avail_len_i = '0;
    logic          tgt_done_i = 1'b0;
    logic          req_valid_o;
    logic          req_ready_i = 1'b0;
    logic [LW-1:0] req_len_o;
    logic          req_dir_o;
    logic          cdone_i = 1'b0;
    logic [RW-1:0] resid_o;
    logic [LW-1:0] remain_o;
    logic [7:0]    status_o;
    logic [7:0]    intr_o;
    logic          cmpl_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_dma_ctl #(.CW(CW), .RW(RW), .CMD_MAX(32)) i_xfer_dma_ctl (
        .clk(clk), .rst_n(rst_n),
        .resid_ld_i(resid_ld_i), .resid_in_i(resid_in_i),
        .start_i(start_i), .cmd_mode_i(cmd_mode_i), .count_i(count_i),
        .avail_vld_i(avail_vld_i), .avail_len_i(avail_len_i),
        .tgt_done_i(tgt_done_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_len_o(req_len_o), .req_dir_o(req_dir_o), .cdone_i(cdone_i),
        .resid_o(resid_o), .remain_o(remain_o),
        .status_o(status_o), .intr_o(intr_o), .cmpl_o(cmpl_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    int m_resid = 0, m_remain = 0, m_avail = 0, m_xsize = 0;
    int m_status = 0, m_intr = 0;
    bit m_cmd = 1'b0;
    bit e_cmpl = 1'b0, e_req = 1'b0, e_dir = 1'b0;
    int e_len = 0;

    function automatic int f_min(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int f_grant(int cnt_raw, bit cmd, int resid);
        int c;
        c = (cnt_raw == 0) ? 65536 : cnt_raw;
        if (cmd) return f_min(c, 32);
        return f_min(c, (resid < 0) ? -resid : resid);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "cmpl_o", int'(cmpl_o), int'(e_cmpl));
        chk(tag, "req_valid_o", int'(req_valid_o), int'(e_req));
        if (e_req) begin
            chk(tag, "req_len_o", int'(req_len_o), e_len);
            chk(tag, "req_dir_o", int'(req_dir_o), int'(e_dir));
        end
        chk(tag, "status_o", int'(status_o), m_status);
        chk(tag, "intr_o", int'(intr_o), m_intr);
        chk(tag, "resid_o", int'($signed(resid_o)), m_resid);
        chk(tag, "remain_o", int'(remain_o), m_remain);
    endtask

    function automatic void complete_m();
        m_status = m_status | 32'h90;
        m_intr   = 32'h10;
        m_xsize  = 0;
        e_cmpl   = 1'b1;
    endfunction

    task automatic do_ld(int v, string tag);
        resid_ld_i = 1'b1;
        resid_in_i = v[RW-1:0];
        @(posedge clk); @(negedge clk);
        resid_ld_i = 1'b0;
        e_cmpl = 1'b0; e_req = 1'b0;
        m_resid  = v;
        m_status = (v < 0) ? 0 : 1;
        check_all(tag);
    endtask

    task automatic do_start(int cnt, bit cmd, string tag);
        int g;
        start_i = 1'b1; count_i = cnt[CW-1:0]; cmd_mode_i = cmd;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; cmd_mode_i = 1'b0;
        e_cmpl = 1'b0; e_req = 1'b0;
        g = f_grant(cnt, cmd, m_resid);
        m_remain = g;
        m_xsize  = (cnt == 0) ? 65536 : cnt;
        m_cmd    = cmd;
        m_status = m_status & 32'hEF;
        if (cmd) begin
            e_req = 1'b1; e_len = g; e_dir = 1'b1;
        end else if (m_avail != 0) begin
            if (f_min(g, m_avail) == 0) complete_m();
            else begin
                e_req = 1'b1; e_len = f_min(g, m_avail); e_dir = (m_resid < 0);
            end
        end
        check_all(tag);
    endtask

    task automatic do_avail(int len, string tag);
        avail_vld_i = 1'b1; avail_len_i = len[LW-1:0];
        @(posedge clk); @(negedge clk);
        avail_vld_i = 1'b0;
        e_cmpl = 1'b0; e_req = 1'b0;
        m_avail = len;
        if (m_remain != 0) begin
            if (len != 0) begin
                e_req = 1'b1; e_len = f_min(m_remain, len); e_dir = (m_resid < 0);
            end
        end else if (m_xsize != 0 && m_resid <= 0) begin
            complete_m();
        end
        check_all(tag);
    endtask

    task automatic do_tdone(string tag);
        tgt_done_i = 1'b1;
        @(posedge clk); @(negedge clk);
        tgt_done_i = 1'b0;
        e_req = 1'b0;
        m_resid = 0; m_remain = 0; m_avail = 0;
        complete_m();
        m_status = 32'h93;
        check_all(tag);
    endtask

    task automatic serve(string tag);
        int w;
        int len;
        bit dir;
        w = $urandom_range(0, 3);
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            e_cmpl = 1'b0;
            check_all("R12");
        end
        req_ready_i = 1'b1;
        @(posedge clk); @(negedge clk);
        req_ready_i = 1'b0;
        len = e_len; dir = e_dir;
        e_cmpl = 1'b0; e_req = 1'b0;
        check_all("R12");
        w = $urandom_range(0, 2);
        for (int i = 0; i < w; i++) @(negedge clk);
        cdone_i = 1'b1;
        @(posedge clk); @(negedge clk);
        cdone_i = 1'b0;
        if (m_cmd) begin
            m_resid = 0; m_remain = 0; m_xsize = 0; m_cmd = 1'b0;
        end else begin
            m_avail  = m_avail - len;
            m_remain = m_remain - len;
            m_resid  = dir ? m_resid + len : m_resid - len;
            if (m_avail != 0) complete_m();
            else if (!dir && m_remain == 0 && m_resid > 0) complete_m();
        end
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired before the run ended");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: zero count decodes to 65536; R11: no data, nothing moves
        do_ld(70000, "R14");
        do_start(0, 1'b0, "R2");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            e_cmpl = 1'b0;
            check_all("R11");
        end
        do_tdone("R9");

        // R13: command-collection chunks
        do_ld(10, "R14");
        do_start(100, 1'b1, "R13"); serve("R13");
        do_start(0, 1'b1, "R13");   serve("R13");
        do_start(5, 1'b1, "R3");    serve("R13");

        // write toward device, deferred completion on next data (R7, R10)
        do_ld(-50, "R14");
        do_start(100, 1'b0, "R4");
        do_avail(20, "R5");  serve("R7");
        do_avail(30, "R10"); serve("R5");
        do_avail(10, "R8");
        do_tdone("R9");

        // read leaving data unconsumed (R6)
        do_ld(100, "R14");
        do_start(40, 1'b0, "R4");
        do_avail(60, "R5"); serve("R6");
        do_tdone("R9");

        // read that drains both remaining and available, residual positive
        do_ld(100, "R14");
        do_start(50, 1'b0, "R3");
        do_avail(50, "R5"); serve("R7");
        do_tdone("R9");

        // read that empties data with residual reaching zero: waits
        do_ld(100, "R14");
        do_start(100, 1'b0, "R3");
        do_avail(40, "R5"); serve("R7");
        do_avail(60, "R5"); serve("R7");
        do_avail(5, "R10");
        do_tdone("R9");

        // zero grant with target data already present: immediate completion
        do_ld(0, "R14");
        do_avail(7, "R11");
        do_start(10, 1'b0, "R8");
        do_tdone("R9");

        // constrained random transfers
        for (int it = 0; it < 250; it++) begin
            int mag;
            int cnt;
            bit cmd;
            mag = $urandom_range(0, 300);
            do_ld(($urandom_range(0, 1) == 1) ? -mag : mag, "R14");
            cnt = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 400);
            cmd = ($urandom_range(0, 7) == 0);
            do_start(cnt, cmd, "R3");
            if (e_req) serve("R5");
            for (int s = 0; s < 5; s++) begin
                if ($urandom_range(0, 9) == 0) begin
                    do_tdone("R9");
                end else begin
                    int len;
                    len = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 200);
                    do_avail(len, "R10");
                    if (e_req) serve("R5");
                end
            end
            if ($urandom_range(0, 1) == 1) do_tdone("R9");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule